// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block is a single-master I2C controller. One command write sets up a whole transfer: the start and stop flags, the transfer direction, a 7-bit device address and a byte count. The block then produces the START condition, shifts out the address byte with the direction bit, checks the acknowledge and moves the requested number of data bytes. It ends with a STOP, or it keeps the bus for a repeated START.

Data moves through two one-byte holding registers, one for each direction, and each has a ready flag. When a byte is due and its holding register has not been serviced, the block holds SCL low until it is. On reads it acknowledges every byte except the last, which it leaves unacknowledged. An address that no device acknowledges raises a sticky flag, and the block closes the bus with STOP. The pins are open-drain style: an output high means "pull the line low".

The controller is built around one state machine. Its states are IDLE (bus free), START (start or repeated-start condition), ADDR (eight address bits), DATA (eight data bits, with the stretch point before the first bit), ACK (ninth clock), STOP (stop condition) and PARK (bus kept with SCL low after a command with no stop flag). The transitions are these:
- IDLE to START and PARK to START happen when a command is accepted.
- START goes to ADDR.
- ADDR goes to ACK.
- ACK goes to DATA when bytes remain. It goes to STOP after an address NAK, or when the count is zero and the stop flag is set. It goes to PARK when the count is zero and the stop flag is clear.
- DATA goes to ACK.
- STOP goes to IDLE.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, `st_idle`=1, `st_txrdy`=1, `st_rxrdy`=0, `st_anak`=0, and both `scl_lo` and `sda_lo` are 0 (lines released).
- R2: A command is accepted only when `cmd_valid`=1, `cmd_start`=1 and the block is in IDLE or PARK. A command presented at any other time has no effect on the transfer in progress. An accepted command produces START (SDA falls while SCL is high) and then the address byte `{cmd_addr, cmd_read}`, MSB first, where read=1.
- R3: SDA changes only while SCL is low, except in a START or STOP condition. Each transfer shows exactly the START and STOP conditions it calls for.
- R4: On the ninth address clock the block samples SDA. If SDA is high, it sets `st_anak`, transfers no data bytes, sends STOP and returns to IDLE. `st_anak` clears when the next command is accepted.
- R5: In write mode each data byte is taken from the transmit holding register and sent MSB first. `st_txrdy`=1 means the holding register is empty. A `tx_wr` while it is full is ignored.
- R6: In write mode, when a byte is due and the transmit holding register is empty, SCL is held low until `tx_wr` supplies the byte.
- R7: In read mode, each byte clocked in appears on `rx_byte` with `st_rxrdy`=1. A one-cycle `rx_rd` clears `st_rxrdy`.
- R8: In read mode, SCL is held low before each byte while `st_rxrdy`=1. No SCL pulse occurs until `rx_rd`.
- R9: On the ninth clock of each received byte, the block drives SDA low (ACK) for every byte except the last, and leaves SDA high (NAK) for the last.
- R10: The count is decremented per byte. When it reaches zero with the stop flag set, STOP follows. `st_idle`=1 only with no active command and both lines released.
- R11: A command with start=1, stop=1 and count=0 produces only START, the address byte and STOP.
- R12: A command with stop=0 leaves the bus in PARK with SCL held low and `st_idle`=0. The next accepted command begins with a repeated START and no STOP in between.
- R13: Every SCL high pulse inside a transfer lasts exactly 2*QUARTER clock cycles. Every SCL low period lasts at least 2*QUARTER cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command write strobe, one cycle |
| cmd_start | input | 1 | Command: generate (repeated) START |
| cmd_stop | input | 1 | Command: send STOP when the count reaches zero |
| cmd_read | input | 1 | Command: 1 = read, 0 = write |
| cmd_addr | input | 7 | Command: device address |
| cmd_count | input | CNT_W | Command: number of data bytes |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_byte | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe, clears the receive ready flag |
| rx_byte | output | 8 | Receive holding register contents |
| st_idle | output | 1 | No command active and bus released |
| st_rxrdy | output | 1 | Receive holding register holds a byte |
| st_txrdy | output | 1 | Transmit holding register is empty |
| st_anak | output | 1 | Last address phase was not acknowledged |
| scl_lo | output | 1 | 1 = pull SCL low |
| sda_lo | output | 1 | 1 = pull SDA low |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The hardest situations to reach are the stretch points. They happen in a single quarter-phase just before the first bit of a byte, and only when software is late. The stimulus provokes them on purpose. It issues a write command with no byte loaded, and it leaves a received byte unread for hundreds of cycles. Over that window it counts SCL rising edges, which must stay at zero. The repeated START out of PARK is reached by chaining a no-stop write into a read command, and the bench slave counts START and STOP conditions to confirm that no STOP appears between them.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_ACK   = 3'd4,
        ST_STOP  = 3'd5,
        ST_PARK  = 3'd6
    } mst_state_t;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

endpackage

// File: rtl/i2cm_quarter_tick.sv
module i2cm_quarter_tick #(
    parameter int QUARTER = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/i2cm_hold_reg.sv
module i2cm_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
        end else begin
            if (take) full <= 1'b0;
            if (load) begin
                full <= 1'b1;
                dout <= din;
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int QUARTER = 4,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cmd_read,
    input  logic [6:0]       cmd_addr,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             tx_wr,
    input  logic [7:0]       tx_byte,
    input  logic             rx_rd,
    output logic [7:0]       rx_byte,
    output logic             st_idle,
    output logic             st_rxrdy,
    output logic             st_txrdy,
    output logic             st_anak,
    output logic             scl_lo,
    output logic             sda_lo,
    input  logic             sda_in
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    mst_state_t        state_q;
    logic [1:0]        q_q;
    logic [2:0]        bit_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              rd_q, stop_q, addr_ph_q, nak_q, anak_q;
    logic              tx_full, rx_full, tx_take, rx_load;
    logic [BYTE_W-1:0] tx_dout;
    logic              stall, run, adv, accept, bit_drv;

    // Stretch point: first quarter of a byte, holding register not serviced
    assign stall  = (state_q == ST_DATA) && (bit_q == 3'd7) && (q_q == 2'd0) &&
                    (rd_q ? rx_full : !tx_full);
    assign run    = (state_q != ST_IDLE) && (state_q != ST_PARK) && !stall;
    assign accept = cmd_valid && cmd_start &&
                    ((state_q == ST_IDLE) || (state_q == ST_PARK));

    i2cm_quarter_tick #(.QUARTER(QUARTER)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(adv)
    );

    assign tx_take = adv && !rd_q && (state_q == ST_DATA) && (bit_q == 3'd7) && (q_q == 2'd0);
    assign rx_load = adv && rd_q && (state_q == ST_DATA) && (bit_q == 3'd0) && (q_q == 2'd3);

    i2cm_hold_reg #(.W(BYTE_W)) u_txh (
        .clk(clk), .rst_n(rst_n), .load(tx_wr && !tx_full), .din(tx_byte),
        .take(tx_take), .full(tx_full), .dout(tx_dout)
    );

    i2cm_hold_reg #(.W(BYTE_W)) u_rxh (
        .clk(clk), .rst_n(rst_n), .load(rx_load), .din(shreg_q),
        .take(rx_rd), .full(rx_full), .dout(rx_byte)
    );

    // Level the master places on SDA in the second quarter of a bit (1 = pull low)
    always_comb begin
        unique case (state_q)
            ST_ADDR: bit_drv = !shreg_q[7];
            ST_DATA: bit_drv = rd_q ? 1'b0 : !shreg_q[7];
            ST_ACK:  bit_drv = (addr_ph_q || !rd_q) ? 1'b0 : (cnt_q != '0);
            default: bit_drv = 1'b0;
        endcase
    end

    // State register and transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            q_q       <= 2'd0;
            bit_q     <= 3'd7;
            shreg_q   <= '0;
            cnt_q     <= '0;
            rd_q      <= 1'b0;
            stop_q    <= 1'b0;
            addr_ph_q <= 1'b0;
            nak_q     <= 1'b0;
            anak_q    <= 1'b0;
        end else if (accept) begin
            state_q   <= ST_START;
            q_q       <= (state_q == ST_IDLE) ? 2'd1 : 2'd0;
            bit_q     <= 3'd7;
            shreg_q   <= {cmd_addr, cmd_read};
            cnt_q     <= cmd_count;
            rd_q      <= cmd_read;
            stop_q    <= cmd_stop;
            addr_ph_q <= 1'b1;
            anak_q    <= 1'b0;
        end else if (adv) begin
            q_q <= q_q + 2'd1;
            unique case (state_q)
                ST_START: if (q_q == 2'd3) state_q <= ST_ADDR;
                ST_ADDR: begin
                    if (q_q == 2'd3) begin
                        shreg_q <= shreg_q << 1;
                        bit_q   <= bit_q - 3'd1;
                        if (bit_q == 3'd0) state_q <= ST_ACK;
                    end
                end
                ST_DATA: begin
                    if (q_q == 2'd0 && bit_q == 3'd7 && !rd_q) shreg_q <= tx_dout;
                    if (q_q == 2'd2 && rd_q) shreg_q <= {shreg_q[6:0], sda_in};
                    if (q_q == 2'd3) begin
                        if (!rd_q) shreg_q <= shreg_q << 1;
                        bit_q <= bit_q - 3'd1;
                        if (bit_q == 3'd0) begin
                            state_q <= ST_ACK;
                            cnt_q   <= cnt_q - CNT_ONE;
                        end
                    end
                end
                ST_ACK: begin
                    if (q_q == 2'd2) nak_q <= sda_in;
                    if (q_q == 2'd3) begin
                        addr_ph_q <= 1'b0;
                        bit_q     <= 3'd7;
                        if (addr_ph_q && nak_q) begin
                            anak_q  <= 1'b1;
                            state_q <= ST_STOP;
                        end else if (cnt_q == '0) begin
                            state_q <= stop_q ? ST_STOP : ST_PARK;
                        end else begin
                            state_q <= ST_DATA;
                        end
                    end
                end
                ST_STOP: if (q_q == 2'd3) state_q <= ST_IDLE;
                default: ;
            endcase
        end
    end

    // Registered pin drivers derived from state and quarter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_lo <= 1'b0;
            sda_lo <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    scl_lo <= 1'b0;
                    sda_lo <= 1'b0;
                end
                ST_START: begin
                    scl_lo <= (q_q == 2'd0);
                    sda_lo <= (q_q >= 2'd2);
                end
                ST_ADDR, ST_DATA, ST_ACK: begin
                    scl_lo <= (q_q < 2'd2);
                    if (q_q == 2'd1) sda_lo <= bit_drv;
                end
                ST_STOP: begin
                    scl_lo <= (q_q < 2'd2);
                    if (q_q == 2'd1) sda_lo <= 1'b1;
                    if (q_q == 2'd3) sda_lo <= 1'b0;
                end
                ST_PARK: scl_lo <= 1'b1;
                default: scl_lo <= 1'b0;
            endcase
        end
    end

    assign st_idle  = (state_q == ST_IDLE) && !scl_lo && !sda_lo;
    assign st_rxrdy = rx_full;
    assign st_txrdy = !tx_full;
    assign st_anak  = anak_q;

    AST_SDA_ONLY_WHEN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_lo && !$past(scl_lo) && $past(state_q) != ST_START && $past(state_q) != ST_STOP)
        |-> $stable(sda_lo)); // R3
    AST_ADDR_NAK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK && addr_ph_q && q_q == 2'd3 && adv && nak_q && !accept)
        |=> (state_q == ST_STOP && anak_q)); // R4
    AST_TX_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !rd_q) |=> scl_lo); // R6
    AST_RX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |-> !rx_full); // R7
    AST_RX_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && rd_q) |=> scl_lo); // R8
    AST_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (cnt_q != '0)); // R10
endmodule

// File: tb/sim_i2c_cmd_master.sv
module sim_i2c_cmd_master;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int HI_LEN     = 2 * Q;
    localparam logic [6:0] SLV = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 0, cmd_start = 0, cmd_stop = 0, cmd_read = 0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_count = '0;
    logic tx_wr = 0, rx_rd = 0;
    logic [7:0] tx_byte = '0;
    logic [7:0] rx_byte;
    logic st_idle, st_rxrdy, st_txrdy, st_anak, scl_lo, sda_lo;
    logic s_drv = 1'b0;
    logic scl_bus, sda_bus;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_bus = !scl_lo;
    assign sda_bus = !(sda_lo || s_drv);

    i2c_cmd_master #(.QUARTER(Q), .CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_rd(rx_rd), .rx_byte(rx_byte),
        .st_idle(st_idle), .st_rxrdy(st_rxrdy), .st_txrdy(st_txrdy), .st_anak(st_anak),
        .scl_lo(scl_lo), .sda_lo(sda_lo), .sda_in(sda_bus)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural bus slave and per-clock protocol model
    logic [7:0] wr_q[$];
    logic [7:0] tx_src_q[$];
    logic [7:0] addr_q[$];
    bit         mack_q[$];
    int n_start = 0, n_stop = 0, n_rise = 0;
    int hi_cnt = 0, lo_cnt = 0, s_bit = 0;
    bit hi_valid = 0, lo_valid = 0, s_act = 0, s_addr_ph = 0, s_match = 0, s_rdm = 0;
    bit s_tx = 0, s_last_ack = 0;
    logic [7:0] s_sh = '0, s_out = '0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (st_idle) chk(scl_bus && sda_bus, "R10 idle-with-bus-released",
                             {scl_bus, sda_bus}, 2'b11);
            if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
                n_start++; s_act = 1; s_addr_ph = 1; s_bit = 0; s_drv = 0;
                s_tx = 0; s_match = 0; hi_valid = 0;
            end else if (prev_scl && scl_bus && !prev_sda && sda_bus) begin
                n_stop++; s_act = 0; s_drv = 0; hi_valid = 0; lo_valid = 0;
            end else if (!prev_scl && scl_bus) begin
                n_rise++;
                if (s_act) begin
                    if (lo_valid) chk(lo_cnt >= HI_LEN, "R13 low period", lo_cnt, HI_LEN);
                    hi_valid = 1;
                    if (s_bit < 8) begin
                        s_sh = {s_sh[6:0], sda_bus}; s_bit++;
                    end else if (s_bit == 9 && s_tx) begin
                        s_last_ack = !sda_bus;
                        mack_q.push_back(!sda_bus);
                    end
                end
            end else if (s_act && prev_scl && !scl_bus) begin
                if (hi_valid) chk(hi_cnt == HI_LEN, "R13 high period", hi_cnt, HI_LEN);
                hi_valid = 0; lo_valid = 1;
                if (s_bit == 8) begin
                    s_bit = 9;
                    if (s_addr_ph) begin
                        addr_q.push_back(s_sh);
                        s_match = (s_sh[7:1] == SLV); s_rdm = s_sh[0]; s_drv = s_match;
                    end else if (!s_tx) begin
                        if (s_match) begin wr_q.push_back(s_sh); s_drv = 1; end
                    end else s_drv = 0;
                end else if (s_bit == 9) begin
                    s_bit = 0;
                    if (s_addr_ph) begin
                        s_addr_ph = 0; s_tx = s_match && s_rdm; s_last_ack = 1;
                    end
                    if (s_tx && s_last_ack) begin
                        s_out = (tx_src_q.size() > 0) ? tx_src_q.pop_front() : 8'hFF;
                        s_drv = !s_out[7];
                    end else begin
                        s_tx = 0; s_drv = 0;
                    end
                end else if (s_tx && s_bit > 0) begin
                    s_drv = !s_out[7 - s_bit];
                end
            end
            if (scl_bus) hi_cnt = prev_scl ? hi_cnt + 1 : 1;
            else         lo_cnt = !prev_scl ? lo_cnt + 1 : 1;
            prev_scl = scl_bus;
            prev_sda = sda_bus;
        end
    end

    // Host-side tasks
    task automatic do_cmd(input bit st, input bit sp, input bit rd, input logic [6:0] a,
                          input logic [7:0] n);
        @(negedge clk);
        cmd_valid = 1; cmd_start = st; cmd_stop = sp; cmd_read = rd; cmd_addr = a; cmd_count = n;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic write_tx(input logic [7:0] b);
        int guard = 0;
        @(negedge clk);
        while (!st_txrdy && guard < 5000) begin @(negedge clk); guard++; end
        tx_wr = 1; tx_byte = b;
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic read_rx(output logic [7:0] b);
        int guard = 0;
        @(negedge clk);
        while (!st_rxrdy && guard < 5000) begin @(negedge clk); guard++; end
        b = rx_byte;
        rx_rd = 1;
        @(negedge clk);
        rx_rd = 0;
        @(negedge clk);
        chk(!st_rxrdy, "R7 rxrdy cleared by read", st_rxrdy, 0);
    endtask

    task automatic wait_idle();
        int guard = 0;
        repeat (3) @(negedge clk);
        while (!st_idle && guard < 8000) begin @(negedge clk); guard++; end
        chk(st_idle, "R10 return to idle", st_idle, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog requirement=all actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int s0, p0, r0, w0, a0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(st_idle && st_txrdy && !st_rxrdy && !st_anak, "R1 status after reset",
            {st_idle, st_txrdy, st_rxrdy, st_anak}, 4'b1100);
        chk(!scl_lo && !sda_lo, "R1 lines released", {scl_lo, sda_lo}, 0);

        // Write three bytes with stop (R2 R5 R10 R3)
        s0 = n_start; p0 = n_stop;
        do_cmd(1, 1, 0, SLV, 3);
        write_tx(8'hA5); write_tx(8'h3C); write_tx(8'hF0);
        wait_idle();
        chk(addr_q.size() == 1 && addr_q[0] == {SLV, 1'b0}, "R2 address byte write",
            addr_q.size() ? addr_q[0] : 0, {SLV, 1'b0});
        chk(wr_q.size() == 3, "R5 byte count written", wr_q.size(), 3);
        if (wr_q.size() == 3) begin
            chk(wr_q[0] == 8'hA5, "R5 byte0", wr_q[0], 8'hA5);
            chk(wr_q[1] == 8'h3C, "R5 byte1", wr_q[1], 8'h3C);
            chk(wr_q[2] == 8'hF0, "R5 byte2", wr_q[2], 8'hF0);
        end
        chk(n_start - s0 == 1 && n_stop - p0 == 1, "R3 one START one STOP",
            (n_start - s0) * 16 + (n_stop - p0), 17);
        chk(!st_anak, "R4 no anak on acked address", st_anak, 0);

        // Write stretch (R6)
        wr_q.delete();
        do_cmd(1, 1, 0, SLV, 1);
        repeat (250) @(negedge clk);
        r0 = n_rise;
        repeat (300) @(negedge clk);
        chk(n_rise == r0, "R6 no SCL pulse while tx empty", n_rise - r0, 0);
        chk(!scl_bus, "R6 SCL held low", scl_bus, 0);
        chk(wr_q.size() == 0, "R6 no byte sent yet", wr_q.size(), 0);
        write_tx(8'h96);
        wait_idle();
        chk(wr_q.size() == 1 && wr_q[0] == 8'h96, "R6 byte after stretch",
            wr_q.size() ? wr_q[0] : 0, 8'h96);

        // Write while full ignored (R5)
        wr_q.delete();
        write_tx(8'h11);
        chk(!st_txrdy, "R5 txrdy low when full", st_txrdy, 0);
        write_tx(8'h22);
        do_cmd(1, 1, 0, SLV, 1);
        wait_idle();
        chk(wr_q.size() == 1 && wr_q[0] == 8'h11, "R5 second write ignored",
            wr_q.size() ? wr_q[0] : 0, 8'h11);
        chk(st_txrdy, "R5 txrdy after consume", st_txrdy, 1);

        // Read three bytes, busy command ignored (R7 R9 R2)
        addr_q.delete(); mack_q.delete();
        tx_src_q.push_back(8'h5E); tx_src_q.push_back(8'h81); tx_src_q.push_back(8'h27);
        do_cmd(1, 1, 1, SLV, 3);
        repeat (40) @(negedge clk);
        do_cmd(1, 1, 0, 7'h15, 2);
        read_rx(b); chk(b == 8'h5E, "R7 read byte0", b, 8'h5E);
        read_rx(b); chk(b == 8'h81, "R7 read byte1", b, 8'h81);
        read_rx(b); chk(b == 8'h27, "R7 read byte2", b, 8'h27);
        wait_idle();
        chk(addr_q.size() == 1 && addr_q[0] == {SLV, 1'b1}, "R2 busy command ignored",
            addr_q.size(), 1);
        chk(mack_q.size() == 3, "R9 three ack slots", mack_q.size(), 3);
        if (mack_q.size() == 3)
            chk(mack_q[0] && mack_q[1] && !mack_q[2], "R9 ack ack nak",
                {mack_q[0], mack_q[1], mack_q[2]}, 3'b110);

        // Read stretch (R8)
        tx_src_q.push_back(8'hC4); tx_src_q.push_back(8'h19);
        do_cmd(1, 1, 1, SLV, 2);
        while (!st_rxrdy) @(negedge clk);
        repeat (60) @(negedge clk);
        r0 = n_rise;
        repeat (300) @(negedge clk);
        chk(n_rise == r0, "R8 no SCL pulse while rx full", n_rise - r0, 0);
        chk(st_rxrdy && rx_byte == 8'hC4, "R8 held byte intact", rx_byte, 8'hC4);
        read_rx(b); chk(b == 8'hC4, "R8 first byte", b, 8'hC4);
        read_rx(b); chk(b == 8'h19, "R8 second byte", b, 8'h19);
        wait_idle();

        // Address NAK (R4)
        wr_q.delete(); p0 = n_stop;
        do_cmd(1, 1, 0, 7'h33, 2);
        wait_idle();
        chk(st_anak, "R4 anak set", st_anak, 1);
        chk(wr_q.size() == 0, "R4 no data after nak", wr_q.size(), 0);
        chk(n_stop - p0 == 1, "R4 stop after nak", n_stop - p0, 1);

        // Zero count (R11) also clears anak (R4)
        addr_q.delete(); s0 = n_start; p0 = n_stop;
        do_cmd(1, 1, 0, SLV, 0);
        @(negedge clk);
        chk(!st_anak, "R4 anak cleared by new command", st_anak, 0);
        wait_idle();
        chk(addr_q.size() == 1 && wr_q.size() == 0, "R11 address only",
            addr_q.size() * 16 + wr_q.size(), 16);
        chk(n_start - s0 == 1 && n_stop - p0 == 1, "R11 start and stop",
            (n_start - s0) * 16 + (n_stop - p0), 17);

        // Park then repeated START (R12)
        wr_q.delete(); addr_q.delete(); s0 = n_start; p0 = n_stop;
        do_cmd(1, 0, 0, SLV, 1);
        write_tx(8'h6B);
        w0 = 0;
        while (wr_q.size() == 0 && w0 < 3000) begin @(negedge clk); w0++; end
        repeat (200) @(negedge clk);
        chk(!st_idle && !scl_bus, "R12 parked with SCL low", {st_idle, scl_bus}, 0);
        chk(n_stop == p0, "R12 no stop while parked", n_stop - p0, 0);
        tx_src_q.push_back(8'hD2);
        do_cmd(1, 1, 1, SLV, 1);
        read_rx(b);
        chk(b == 8'hD2, "R12 read after repeated start", b, 8'hD2);
        wait_idle();
        a0 = addr_q.size();
        chk(a0 == 2 && addr_q[a0 - 1] == {SLV, 1'b1}, "R12 second address read",
            a0 ? addr_q[a0 - 1] : 0, {SLV, 1'b1});
        chk(n_start - s0 == 2 && n_stop - p0 == 1, "R12 repeated start one stop",
            (n_start - s0) * 16 + (n_stop - p0), 33);
        chk(wr_q.size() == 1 && wr_q[0] == 8'h6B, "R12 parked write byte",
            wr_q.size() ? wr_q[0] : 0, 8'h6B);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule